// File: doc/BRIEF.md
# Precomputed Low-Power Unsigned Greater-Than Comparator

This block compares two unsigned operands and reports whether the first is strictly larger than the second. It registers its operands and drives the flag from those registers, so the answer for a pair presented before a rising clock edge is visible just after that edge. To save switching energy, it splits each operand into its top bit and the remaining low bits. The top bits of both operands are captured on every edge. A small predictor looks at the two incoming top bits. If they differ, the answer is already known from them alone. In that case the low-bit registers are not loaded.

The low-bit registers are written only when the two top bits match, because only then do the low bits affect the result. In cycles where the top bits differ, the low-bit registers and the comparator logic behind them keep their old values. Nothing toggles there. The flag is always a function of registers only, so it is glitch-free with respect to operand changes between edges.

The interface is plain: one operand pair is taken on every edge and one flag is produced. There is no handshake. A continuous stream is the intended use. Reset is synchronous and active high.

Top module: `precomp_gt_cmp`

## Requirements
- R1: While reset is high at a rising edge, every register is cleared, so after that edge `gt` reads 0.
- R2: After each rising edge with reset low, `gt` equals 1 exactly when the unsigned operand `op_a` sampled at that edge exceeds `op_b` sampled at that edge.
- R3: When the sampled top bits (bit WIDTH-1) of the two operands differ, `gt` after the edge equals the top bit of `op_a`, whatever the low bits carry.
- R4: When the sampled top bits differ, the low-bit registers of both operands keep their previous contents across that edge.
- R5: When the sampled top bits are equal, the low-bit registers take the new low bits at that edge. This holds even directly after a run of edges where they were held, so the result uses fresh low bits.
- R6: Equal operands give `gt` = 0.
- R7: A reset asserted in the middle of a stream clears `gt` at the next edge, even if the operands held at that edge would give 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | Unsigned operand tested as the larger one |
| op_b | input | WIDTH | Unsigned operand it is compared against |
| gt | output | 1 | 1 when the operand pair sampled at the last edge had op_a > op_b |

## Verification
The bench builds the block with WIDTH = 8. At that width every one of the 65,536 operand pairs can be driven back to back. This sweep covers every top-bit combination. It also covers every transition from held low registers back to loading, and every equal-operand case, which are R2 to R6. Directed steps surround the sweep: a reset check at start, a long run with differing top bits and extreme low bits, and a reset in mid-stream. The bench also counts the edges on which the low registers were left idle, computing this from the stimulus alone.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

  // Outcome of looking at the two operand top bits only.
  typedef struct packed {
    logic force_hi;  // result known to be 1
    logic force_lo;  // result known to be 0
    logic load;      // low bits are needed
  } pcmp_pred_t;

  function automatic logic top_decides_gt(input logic a_top, input logic b_top);
    return a_top & ~b_top;
  endfunction

endpackage

// File: rtl/pcmp_predictor.sv
module pcmp_predictor
  import pcmp_pkg::*;
(
  input  logic       a_top,
  input  logic       b_top,
  output pcmp_pred_t pred
);

  always_comb begin
    pred.force_hi = a_top & ~b_top;
    pred.force_lo = ~a_top & b_top;
    // Either prediction firing makes the low bits irrelevant.
    pred.load     = ~(pred.force_hi | pred.force_lo);
  end

endmodule

// File: rtl/pcmp_bank.sv
module pcmp_bank #(
  parameter int BITS = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);

  for (genvar k = 0; k < BITS; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        q[k] <= 1'b0;
      end else if (load) begin
        q[k] <= d[k];
      end
    end
  end

endmodule

// File: rtl/pcmp_resolve.sv
module pcmp_resolve
  import pcmp_pkg::*;
#(
  parameter int LOW_W = 7
) (
  input  logic             a_top_q,
  input  logic             b_top_q,
  input  logic [LOW_W-1:0] a_low_q,
  input  logic [LOW_W-1:0] b_low_q,
  output logic             gt
);

  logic tops_differ;

  always_comb begin
    tops_differ = a_top_q ^ b_top_q;
    if (tops_differ) begin
      gt = top_decides_gt(a_top_q, b_top_q);
    end else begin
      gt = (a_low_q > b_low_q);
    end
  end

endmodule

// File: rtl/precomp_gt_cmp.sv
module precomp_gt_cmp
  import pcmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             gt
);

  localparam int LOW_W = WIDTH - 1;
  localparam int TOP   = WIDTH - 1;

  pcmp_pred_t       pred;
  logic             top_a_q;
  logic             top_b_q;
  logic [LOW_W-1:0] lo_a_q;
  logic [LOW_W-1:0] lo_b_q;

  pcmp_predictor u_pred (
    .a_top (op_a[TOP]),
    .b_top (op_b[TOP]),
    .pred  (pred)
  );

  // Top bits are captured on every edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      top_a_q <= 1'b0;
      top_b_q <= 1'b0;
    end else begin
      top_a_q <= op_a[TOP];
      top_b_q <= op_b[TOP];
    end
  end

  pcmp_bank #(.BITS(LOW_W)) u_lo_a (
    .clk  (clk),
    .rst  (rst),
    .load (pred.load),
    .d    (op_a[LOW_W-1:0]),
    .q    (lo_a_q)
  );

  pcmp_bank #(.BITS(LOW_W)) u_lo_b (
    .clk  (clk),
    .rst  (rst),
    .load (pred.load),
    .d    (op_b[LOW_W-1:0]),
    .q    (lo_b_q)
  );

  pcmp_resolve #(.LOW_W(LOW_W)) u_res (
    .a_top_q (top_a_q),
    .b_top_q (top_b_q),
    .a_low_q (lo_a_q),
    .b_low_q (lo_b_q),
    .gt      (gt)
  );

endmodule

// File: rtl/pcmp_chk.sv
module pcmp_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             gt,
  input logic [WIDTH-2:0] lo_a_q,
  input logic [WIDTH-2:0] lo_b_q
);

  localparam int TOP = WIDTH - 1;

  logic had_rst = 1'b0;
  logic live    = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) had_rst <= 1'b1;
    live <= had_rst & ~rst;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    had_rst && $past(rst) |-> !gt);

  // R2
  full_compare_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> gt == ($past(op_a) > $past(op_b)));

  // R3
  msb_decide_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(op_a[TOP] != op_b[TOP]) |-> gt == $past(op_a[TOP]));

  // R4
  lower_hold_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(op_a[TOP] != op_b[TOP]) |-> $stable(lo_a_q) && $stable(lo_b_q));

  // R5
  lower_load_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(op_a[TOP] == op_b[TOP]) |->
      lo_a_q == $past(op_a[TOP-1:0]) && lo_b_q == $past(op_b[TOP-1:0]));

endmodule

bind precomp_gt_cmp pcmp_chk #(.WIDTH(WIDTH)) u_pcmp_chk (
  .clk    (clk),
  .rst    (rst),
  .op_a   (op_a),
  .op_b   (op_b),
  .gt     (gt),
  .lo_a_q (lo_a_q),
  .lo_b_q (lo_b_q)
);

// File: tb/test_precomp_gt_cmp.sv
`timescale 1ns/1ps
module test_precomp_gt_cmp;

  localparam int WIDTH = 8;
  localparam int TOP   = WIDTH - 1;
  localparam int SPAN  = 1 << WIDTH;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] op_a = '0;
  logic [WIDTH-1:0] op_b = '0;
  logic             gt;

  int    n_checks = 0;
  int    n_errors = 0;
  int    idle_edges = 0;
  bit    done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  precomp_gt_cmp #(.WIDTH(WIDTH)) i_precomp_gt_cmp (
    .clk  (clk),
    .rst  (rst),
    .op_a (op_a),
    .op_b (op_b),
    .gt   (gt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: gt=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: presents one pair and records what the reference comparator says.
  task automatic drive(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input string tag);
    @(negedge clk);
    op_a = a;
    op_b = b;
    if (a[TOP] != b[TOP]) idle_edges++;
    exp_q.push_back(a > b);
    tag_q.push_back(tag);
  endtask

  // Monitor: result of a pair is valid just after the edge that sampled it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(gt === e, t, int'(gt), int'(e));
      end
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: gt=%0d expected=finished run", gt);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    bit prev_differ;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(gt === 1'b0, "R1", int'(gt), 0);
    @(negedge clk);
    rst = 1'b0;

    // R3 R4: long stretch with differing top bits and extreme low bits
    drive(8'h80, 8'h7F, "R3");
    drive(8'h00, 8'hFF, "R3");
    drive(8'hFF, 8'h00, "R4");
    drive(8'h80, 8'h7F, "R4");
    drive(8'h7F, 8'h80, "R4");
    // R5: equal tops right after the held stretch
    drive(8'h01, 8'h00, "R5");
    drive(8'h81, 8'h80, "R5");
    drive(8'hC0, 8'h3F, "R3");
    drive(8'h40, 8'h3F, "R5");
    // R6: equal operands
    drive(8'h00, 8'h00, "R6");
    drive(8'hFF, 8'hFF, "R6");
    drive(8'h80, 8'h80, "R6");

    // R2: exhaustive sweep against the reference comparator
    prev_differ = 1'b0;
    for (int i = 0; i < SPAN; i++) begin
      for (int j = 0; j < SPAN; j++) begin
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        bit differ;
        a = WIDTH'(i);
        b = WIDTH'(j);
        differ = (a[TOP] != b[TOP]);
        if (differ)            drive(a, b, "R3/R4");
        else if (a == b)       drive(a, b, "R6");
        else if (prev_differ)  drive(a, b, "R5");
        else                   drive(a, b, "R2");
        prev_differ = differ;
      end
    end

    // R7: reset in mid-stream with operands that would give 1
    drive(8'hFF, 8'h00, "R2");
    @(posedge clk);
    #3;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #3;
    check(gt === 1'b0, "R7", int'(gt), 0);
    @(negedge clk);
    rst = 1'b0;
    drive(8'h05, 8'h04, "R7");
    repeat (3) @(posedge clk);
    #3;

    $display("low registers idle on %0d edges", idle_edges);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule